// File: doc/BRIEF.md
# Line-Doubled Monochrome Scanout Engine

The engine turns a one-bit-per-pixel framebuffer into a serial pixel stream for a raster display. An external sync generator sends a one-cycle start-of-line strobe together with the index of the line that begins. When that line falls inside the vertical active window, the engine reads the words of the current framebuffer row from a synchronous read port. Each read returns its data one cycle after the request. The engine then shifts the words out one pixel per clock.

Every framebuffer row is shown on two consecutive display lines, so the framebuffer has half the vertical resolution of the display. Whether a line repeats the current row or moves the row pointer on afterwards depends on the parity of the line's distance from the first active line. A strobe for any line outside the window keeps the output quiet and returns the row pointer to the framebuffer base, ready for the next frame. Each line reads a few words past the visible width. The row stride, counted in 16-bit words, must be at least that per-line word count.

Top module: `scan_engine`

## Requirements
- R1: Pixels leave as 16-bit words, least significant bit first. Pixel k of a line is bit (k mod 16) of the (k div 16)-th word read for that line.
- R2: An active line reads exactly ((WIDTH_PX/8)+2)/2 words, which is 5 with the defaults. The reads go to consecutive addresses starting at the row start address, and the start address and the word count are reloaded at every active strobe.
- R3: No line issues more reads than the per-line word count.
- R4: A strobe whose line index lies outside [VACT_FIRST, VACT_FIRST+VACT_LINES) issues no read and leaves pix_o low for that line.
- R5: pix_o is low during reset, before the first word of a line is loaded, and after the last bit of the line has been shifted out.
- R6: Display lines at offsets 2n and 2n+1 from VACT_FIRST show the same row, n. The row pointer advances by STRIDE_W words only after a line with odd offset.
- R7: A strobe outside the active window returns the row pointer to BASE_ADDR, so the next active line reads from BASE_ADDR.
- R8: The first pixel of an active line appears in the cycle after the third rising edge that follows the strobe edge. All 16 x word-count pixels then follow on consecutive cycles with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle strobe at the start of every display line |
| line_idx_i | input | LINE_W | Index of the line that starts with the strobe |
| mem_re_o | output | 1 | Framebuffer read request |
| mem_addr_o | output | ADDR_W | Framebuffer word address |
| mem_rdata_i | input | 16 | Read data, valid the cycle after the request |
| pix_o | output | 1 | Serial pixel bit |

## Verification
A wrong row pointer shows up in the first read of the line that follows. The address pins then disagree with the row the line index implies, and the pixel stream of that line differs from the model from the third cycle after the strobe onwards. A wrong word count or a missing prefetch appears at the word boundary where it matters: a word too many or too few shows at the end of the line, and a gap delays every later bit by at least one cycle. Comparing each pair of lines with each other catches doubling faults even when the individual addresses look reasonable.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  // words per line, padding included
  function automatic int unsigned burst_words(int unsigned width_px);
    return ((width_px / 8) + 2) / 2;
  endfunction
endpackage

// File: rtl/scan_rowptr.sv
module scan_rowptr #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned STRIDE_W   = 6,
  parameter int unsigned BASE_ADDR  = 16,
  parameter int unsigned VACT_FIRST = 3,
  parameter int unsigned VACT_LINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] line_idx_i,
  output logic              arm_o,
  output logic [ADDR_W-1:0] row_ptr_o
);
  localparam logic [LINE_W-1:0] WIN_LO = LINE_W'(VACT_FIRST);
  localparam logic [LINE_W:0]   WIN_HI = (LINE_W+1)'(VACT_FIRST + VACT_LINES);
  localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(STRIDE_W);

  logic in_win, odd_line;
  logic [ADDR_W-1:0] row_q;

  assign in_win   = (line_idx_i >= WIN_LO) && ({1'b0, line_idx_i} < WIN_HI);
  // parity of (line - first active line)
  assign odd_line = line_idx_i[0] ^ WIN_LO[0];
  assign arm_o    = line_start_i & in_win;
  assign row_ptr_o = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= BASE;
    end else if (line_start_i) begin
      if (!in_win)       row_q <= BASE;
      else if (odd_line) row_q <= row_q + STEP;
    end
  end
endmodule

// File: rtl/scan_fetch.sv
module scan_fetch #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BURST  = 5,
  localparam int unsigned CNT_W = $clog2(BURST + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  arm_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic                  consume_i,
  input  scan_pkg::word_t       rdata_i,
  output logic                  re_o,
  output logic [ADDR_W-1:0]     addr_o,
  output scan_pkg::word_t       buf_o,
  output logic                  buf_valid_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              rd_pend_q, buf_valid_q;
  scan_pkg::word_t   buf_q;

  // one word in flight or held at a time; 16 cycles per word hides the read latency
  assign re_o        = (left_q != '0) && !buf_valid_q && !rd_pend_q && !flush_i;
  assign addr_o      = addr_q;
  assign buf_o       = buf_q;
  assign buf_valid_o = buf_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      left_q      <= '0;
      rd_pend_q   <= 1'b0;
      buf_valid_q <= 1'b0;
      buf_q       <= '0;
    end else if (flush_i) begin
      addr_q      <= start_addr_i;
      left_q      <= arm_i ? CNT_W'(BURST) : '0;
      rd_pend_q   <= 1'b0;
      buf_valid_q <= 1'b0;
    end else begin
      rd_pend_q <= re_o;
      if (re_o) begin
        addr_q <= addr_q + ADDR_W'(1);
        left_q <= left_q - CNT_W'(1);
      end
      if (rd_pend_q) begin
        buf_q       <= rdata_i;
        buf_valid_q <= 1'b1;
      end else if (consume_i) begin
        buf_valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scan_shift.sv
module scan_shift (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  scan_pkg::word_t buf_i,
  input  logic            buf_valid_i,
  output logic            consume_o,
  output logic            pix_o
);
  localparam int unsigned W     = scan_pkg::WORD_W;
  localparam int unsigned BIT_W = $clog2(W + 1);

  scan_pkg::word_t  sh_q;
  logic [BIT_W-1:0] bits_q;
  logic             need;

  // reload on the last bit so words join without a gap
  assign need      = (bits_q <= BIT_W'(1));
  assign consume_o = need & buf_valid_i;
  assign pix_o     = (bits_q != '0) & sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bits_q <= '0;
    end else if (flush_i) begin
      bits_q <= '0;
    end else if (consume_o) begin
      sh_q   <= buf_i;
      bits_q <= BIT_W'(W);
    end else if (bits_q != '0) begin
      sh_q   <= sh_q >> 1;
      bits_q <= bits_q - BIT_W'(1);
    end
  end
endmodule

// File: rtl/scan_engine.sv
module scan_engine #(
  parameter int unsigned WIDTH_PX   = 64,
  parameter int unsigned STRIDE_W   = 6,
  parameter int unsigned BASE_ADDR  = 16,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned VACT_FIRST = 3,
  parameter int unsigned VACT_LINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] line_idx_i,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              pix_o
);
  localparam int unsigned BURST = scan_pkg::burst_words(WIDTH_PX);

  logic              arm;
  logic [ADDR_W-1:0] row_ptr;
  logic              consume, buf_valid;
  scan_pkg::word_t   buf_word;

  scan_rowptr #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .STRIDE_W(STRIDE_W),
    .BASE_ADDR(BASE_ADDR), .VACT_FIRST(VACT_FIRST), .VACT_LINES(VACT_LINES)
  ) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
    .line_idx_i(line_idx_i), .arm_o(arm), .row_ptr_o(row_ptr)
  );

  scan_fetch #(.ADDR_W(ADDR_W), .BURST(BURST)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(line_start_i), .arm_i(arm),
    .start_addr_i(row_ptr), .consume_i(consume), .rdata_i(mem_rdata_i),
    .re_o(mem_re_o), .addr_o(mem_addr_o), .buf_o(buf_word),
    .buf_valid_o(buf_valid)
  );

  scan_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(line_start_i),
    .buf_i(buf_word), .buf_valid_i(buf_valid),
    .consume_o(consume), .pix_o(pix_o)
  );
endmodule

// File: rtl/scan_engine_chk.sv
module scan_engine_chk #(
  parameter int unsigned WIDTH_PX   = 64,
  parameter int unsigned STRIDE_W   = 6,
  parameter int unsigned BASE_ADDR  = 16,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned VACT_FIRST = 3,
  parameter int unsigned VACT_LINES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_start_i,
  input logic [LINE_W-1:0] line_idx_i,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] row_ptr_i
);
  localparam int unsigned BURST = scan_pkg::burst_words(WIDTH_PX);
  localparam int unsigned CNT_W = $clog2(BURST + 2);

  logic in_win, odd_line;
  logic [CNT_W-1:0] rd_cnt;

  assign in_win   = (int'(line_idx_i) >= int'(VACT_FIRST)) &&
                    (int'(line_idx_i) < int'(VACT_FIRST + VACT_LINES));
  assign odd_line = ((int'(line_idx_i) - int'(VACT_FIRST)) % 2) != 0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rd_cnt <= '0;
    else if (line_start_i) rd_cnt <= '0;
    else if (mem_re_o)     rd_cnt <= rd_cnt + CNT_W'(1);
  end

  assert_idle_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && !in_win |=> !mem_re_o);
  assert_first_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && in_win |=> mem_re_o && mem_addr_o == $past(row_ptr_i));
  assert_row_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && in_win && !odd_line |=> $stable(row_ptr_i));
  assert_row_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && in_win && odd_line |=> row_ptr_i == $past(row_ptr_i) + ADDR_W'(STRIDE_W));
  assert_rewind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && !in_win |=> row_ptr_i == ADDR_W'(BASE_ADDR));
  assert_burst_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> rd_cnt < CNT_W'(BURST));
endmodule

bind scan_engine scan_engine_chk #(
  .WIDTH_PX(WIDTH_PX), .STRIDE_W(STRIDE_W), .BASE_ADDR(BASE_ADDR),
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .VACT_FIRST(VACT_FIRST), .VACT_LINES(VACT_LINES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
  .line_idx_i(line_idx_i), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
  .row_ptr_i(row_ptr)
);

// File: tb/tb_scan_engine.sv
module tb_scan_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH_PX   = 64;
  localparam int STRIDE_W   = 6;
  localparam int BASE_ADDR  = 16;
  localparam int VF         = 3;
  localparam int VL         = 8;
  localparam int VTOT       = 14;
  localparam int BURST      = ((WIDTH_PX / 8) + 2) / 2;
  localparam int LBITS      = 16 * BURST;
  localparam int LINE_CYC   = LBITS + 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ls = 1'b0;
  logic [9:0]  li = '0;
  logic        mem_re;
  logic [11:0] mem_addr;
  logic [15:0] rdata = '0;
  logic        pix;

  scan_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(ls), .line_idx_i(li),
    .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_rdata_i(rdata), .pix_o(pix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] fb_word(int a);
    int t;
    t = a * 40503 + 12345;
    return t[15:0] ^ 16'h5AC3;
  endfunction

  always @(posedge clk) if (mem_re) rdata <= fb_word(int'(mem_addr));

  int edge_cnt = 0;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  bit chk_on = 1'b0;
  int start_e = -100000;
  bit act = 1'b0;
  int row = 0;
  int rd_idx = 0;
  int first_addr = -1;
  logic [LBITS-1:0] cap, prev_cap, exp_vec;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    int  k;
    logic e;
    logic [15:0] w;
    if (chk_on) begin
      k = edge_cnt - start_e - 3;
      e = 1'b0;
      if (act && k >= 0 && k < LBITS) begin
        w = fb_word(BASE_ADDR + row * STRIDE_W + k / 16);
        e = w[k % 16];
        cap[k] = pix;
        check(pix === e, "R8", "pixel in burst", pix, e);
      end else begin
        check(pix === 1'b0, "R5", "pixel outside burst", pix, 0);
      end
      if (mem_re) begin
        check(act, "R4", "read on blank line", 1, 0);
        check(rd_idx < BURST, "R3", "read count", rd_idx + 1, BURST);
        check(int'(mem_addr) == BASE_ADDR + row * STRIDE_W + rd_idx, "R2", "read address",
              mem_addr, BASE_ADDR + row * STRIDE_W + rd_idx);
        if (rd_idx == 0) first_addr = int'(mem_addr);
        rd_idx++;
      end
    end
  end

  task automatic drive_line(input int idx);
    int off;
    @(negedge clk);
    ls = 1'b1; li = 10'(idx);
    start_e = edge_cnt + 1;
    act = (idx >= VF) && (idx < VF + VL);
    off = idx - VF;
    row = act ? off / 2 : 0;
    rd_idx = 0; first_addr = -1; cap = '0;
    @(negedge clk);
    ls = 1'b0;
    repeat (LINE_CYC) @(negedge clk);
    if (act) begin
      check(rd_idx == BURST, "R2", "words per line", rd_idx, BURST);
      for (int j = 0; j < BURST; j++)
        exp_vec[16*j +: 16] = fb_word(BASE_ADDR + row * STRIDE_W + j);
      check(cap == exp_vec, "R1", "line lsb-first word order", cap, exp_vec);
      if (off % 2 == 1) check(cap == prev_cap, "R6", "line pair equal", cap, prev_cap);
      prev_cap = cap;
    end else begin
      check(rd_idx == 0, "R4", "reads on blank line", rd_idx, 0);
    end
  endtask

  task automatic first_line_check();
    check(first_addr == BASE_ADDR, "R7", "frame restarts at base", first_addr, BASE_ADDR);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pix === 1'b0, "R5", "pix in reset", pix, 0);
    check(mem_re === 1'b0, "R4", "read in reset", mem_re, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1'b1;
    for (int f = 0; f < 2; f++) begin
      for (int l = 0; l < VTOT; l++) begin
        drive_line(l);
        if (l == VF) first_line_check();
      end
    end
    // cut frame short: blank mid-frame, then restart at the first active line
    drive_line(VF); drive_line(VF + 1); drive_line(VF + 2);
    drive_line(VTOT + 5);
    drive_line(VF);
    first_line_check();
    drive_line(VF + 1); drive_line(VF + 2); drive_line(VF + 3);
    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule